// File: doc/BRIEF.md
# Sticky Maskable Interrupt Register Set

This block gathers hardware event pulses into sticky interrupt bits and drives one level-high interrupt line. A one-cycle pulse on an event input records that event in a source register. A mask register decides which recorded events reach the pending view and the interrupt line. Software reads the three registers through a simple word-addressed port. It acknowledges events by writing ones to either the source register or the pending register.

The event lane order is fixed. Lane 0 is "transfer queued" and lane 1 is "transfer completed". The same lane order is used in the source, mask and pending registers. The number of lanes is a parameter, and the two-lane default matches that pair of events.

The word offsets are parameters: source at 0, mask at 1, pending at 2 by default. Every other offset is unused. A write to an unused offset changes nothing, and a read from one returns zero.

Top module: `irq_evt_unit`

## Requirements
- R1: After reset every source bit is 0, every mask bit is 1 (all events disabled), the pending read is 0 and `irq` is low.
- R2: A pulse on `evtPulse[i]` sets source bit i at the next clock edge. The bit stays 1 through further pulses and through any cycle with no clearing write. Lane 0 is the queued event and lane 1 is the completed event.
- R3: A read at the pending offset (2) returns source AND NOT mask in the low lanes and zero above them. A mask bit of 1 blocks that lane.
- R4: Events are recorded whatever the mask holds. Clearing a mask bit whose source bit is already set makes that lane pending, and raises `irq`, in the cycle right after the mask write.
- R5: `irq` is high exactly when at least one pending bit is 1.
- R6: A write at the source offset (0) clears every source bit whose `wrData` bit is 1, and several bits can be cleared in one write. Lanes written with 0 keep their value. The write never sets a bit.
- R7: A write at the pending offset (2) clears the source bits written with 1, even for a lane that is masked. Lanes written with 0 keep their value.
- R8: When an event pulse and a clearing write hit the same lane in the same cycle, the lane ends up set.
- R9: The mask register at offset 1 reads back the last value written to it. A write to any offset other than 0, 1 or 2 changes no register, and a read from such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| evtPulse | input | NUM_EVT | One bit per event lane; a 1 records the event |
| wrEn | input | 1 | Register write strobe for one cycle |
| wrAddr | input | ADDR_W | Word offset of the write |
| wrData | input | NUM_EVT | Write data, one bit per event lane |
| rdAddr | input | ADDR_W | Word offset of the read |
| rdData | output | DATA_W | Read data, combinational from `rdAddr` and the register state |
| irq | output | 1 | Level-high interrupt, OR of the pending bits |

## Verification
The bench builds the unit with its defaults: two event lanes, a 4-bit offset and a 32-bit read word. With these values every combination of the two lanes, both mask bits and the unused offsets 3 and above can be reached in a few hundred cycles. The directed part covers the difficult orderings. These are an unmask after an event recorded under the mask, a clear of a masked lane through the pending offset, and an event colliding with a clear on the same lane. A random phase with occasional resets then checks `irq` and the addressed read word against a behavioural model on every cycle.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  // Which register the read port is looking at.
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_SRC  = 2'd1,
    RD_MASK = 2'd2,
    RD_PEND = 2'd3
  } rd_sel_e;

  // Strobes handed from the decoder to the register datapath.
  typedef struct packed {
    logic    maskWr;  // load mask from write data
    logic    evtClr;  // clear source bits written with 1
    rd_sel_e rdSel;   // read multiplexer select
  } ctrl_strobes_t;

endpackage

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int SRC_OFS  = 0,
  parameter int MASK_OFS = 1,
  parameter int PEND_OFS = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrl_strobes_t     strobes
);

  localparam logic [ADDR_W-1:0] SRC_A  = ADDR_W'(SRC_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);

  logic wrSrc;
  logic wrMask;
  logic wrPend;

  always_comb begin
    wrSrc  = wrEn && (wrAddr == SRC_A);
    wrMask = wrEn && (wrAddr == MASK_A);
    wrPend = wrEn && (wrAddr == PEND_A);
  end

  // Both the source and the pending offsets acknowledge events.
  always_comb begin
    strobes        = '0;
    strobes.maskWr = wrMask;
    strobes.evtClr = wrSrc || wrPend;
    if (rdAddr == SRC_A)       strobes.rdSel = RD_SRC;
    else if (rdAddr == MASK_A) strobes.rdSel = RD_MASK;
    else if (rdAddr == PEND_A) strobes.rdSel = RD_PEND;
    else                       strobes.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_evt_datapath.sv
module irq_evt_datapath
  import irq_evt_pkg::*;
#(
  parameter int NUM_EVT = 2,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [NUM_EVT-1:0] wrData,
  input  ctrl_strobes_t      strobes,
  output logic [NUM_EVT-1:0] srcQ,
  output logic [NUM_EVT-1:0] maskQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] pendV;

  // One sticky cell per lane; a set beats a same-cycle clear.
  for (genvar i = 0; i < NUM_EVT; i++) begin : gSrcCell
    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcQ[i] <= 1'b0;
      end else if (evtPulse[i]) begin
        srcQ[i] <= 1'b1;
      end else if (strobes.evtClr && wrData[i]) begin
        srcQ[i] <= 1'b0;
      end
    end
  end

  // Mask bit 1 disables a lane; the reset value disables all.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '1;
    end else if (strobes.maskWr) begin
      maskQ <= wrData;
    end
  end

  always_comb begin
    pendV = srcQ & ~maskQ;
    irq   = |pendV;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_SRC:  rdData = {{PAD_W{1'b0}}, srcQ};
      RD_MASK: rdData = {{PAD_W{1'b0}}, maskQ};
      RD_PEND: rdData = {{PAD_W{1'b0}}, pendV};
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_evt_unit.sv
module irq_evt_unit
  import irq_evt_pkg::*;
#(
  parameter int NUM_EVT  = 2,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int SRC_OFS  = 0,
  parameter int MASK_OFS = 1,
  parameter int PEND_OFS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_EVT-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  ctrl_strobes_t      strobes;
  logic [NUM_EVT-1:0] srcQ;
  logic [NUM_EVT-1:0] maskQ;

  irq_evt_ctrl #(
    .ADDR_W  (ADDR_W),
    .SRC_OFS (SRC_OFS),
    .MASK_OFS(MASK_OFS),
    .PEND_OFS(PEND_OFS)
  ) uCtrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .strobes(strobes)
  );

  irq_evt_datapath #(
    .NUM_EVT(NUM_EVT),
    .DATA_W (DATA_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .evtPulse(evtPulse),
    .wrData  (wrData),
    .strobes (strobes),
    .srcQ    (srcQ),
    .maskQ   (maskQ),
    .rdData  (rdData),
    .irq     (irq)
  );

endmodule

// File: rtl/irq_evt_checker.sv
module irq_evt_checker #(
  parameter int NUM_EVT  = 2,
  parameter int ADDR_W   = 4,
  parameter int SRC_OFS  = 0,
  parameter int MASK_OFS = 1,
  parameter int PEND_OFS = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtPulse,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [NUM_EVT-1:0] wrData,
  input logic [NUM_EVT-1:0] srcQ,
  input logic [NUM_EVT-1:0] maskQ,
  input logic               irq
);

  localparam logic [ADDR_W-1:0] SRC_A  = ADDR_W'(SRC_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);

  logic clrWr;
  logic maskWr;
  assign clrWr  = wrEn && (wrAddr == SRC_A || wrAddr == PEND_A);
  assign maskWr = wrEn && (wrAddr == MASK_A);

  // R1: state right after reset release
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (srcQ == '0 && maskQ == '1 && !irq));

  // R2 and R8: a pulse always leaves its lane set, even against a clear
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((srcQ & $past(evtPulse)) == $past(evtPulse)));

  // R2: without a clearing write no recorded bit drops
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((srcQ & $past(srcQ)) == $past(srcQ)));

  // R6, R7: ones clear lanes without a colliding event
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((srcQ & $past(wrData & ~evtPulse)) == '0));

  // R6, R7: lanes written with 0 keep their recorded value
  assert_zero_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((srcQ & $past(srcQ & ~wrData)) == $past(srcQ & ~wrData)));

  // R9: mask loads on its own offset and holds otherwise
  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    maskWr |=> (maskQ == $past(wrData)));
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !maskWr |=> $stable(maskQ));

  // R5: irq needs a recorded event, and a full mask silences it
  assert_irq_needs_event_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (srcQ != '0));
  assert_full_mask_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '1) |-> !irq);

endmodule

bind irq_evt_unit irq_evt_checker #(
  .NUM_EVT (NUM_EVT),
  .ADDR_W  (ADDR_W),
  .SRC_OFS (SRC_OFS),
  .MASK_OFS(MASK_OFS),
  .PEND_OFS(PEND_OFS)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .evtPulse(evtPulse),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .srcQ    (srcQ),
  .maskQ   (maskQ),
  .irq     (irq)
);

// File: tb/tb_irq_evt_unit.sv
module tb_irq_evt_unit;

  localparam int NUM_EVT = 2;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_EVT-1:0] evtPulse = '0;
  logic               wrEn = 1'b0;
  logic [ADDR_W-1:0]  wrAddr = '0;
  logic [NUM_EVT-1:0] wrData = '0;
  logic [ADDR_W-1:0]  rdAddr = '0;
  logic [DATA_W-1:0]  rdData;
  logic               irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_evt_unit dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .irq(irq)
  );

  // Behavioural model: offsets 0 source, 1 mask, 2 pending.
  int refSrc = 0;
  int refMask = 3;

  always @(posedge clk) begin
    int clr;
    if (!rstN) begin
      refSrc = 0;
      refMask = 3;
    end else begin
      clr = (wrEn && (wrAddr == 0 || wrAddr == 2)) ? int'(wrData) : 0;
      refSrc = ((refSrc & ~clr) | int'(evtPulse)) & 3;
      if (wrEn && wrAddr == 1) refMask = int'(wrData);
    end
  end

  function automatic int expRead(input logic [ADDR_W-1:0] a);
    case (a)
      0: return refSrc;
      1: return refMask;
      2: return refSrc & ~refMask & 3;
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(input logic [ADDR_W-1:0] a);
    case (a)
      0: return "R2";
      2: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R5", "irq vs model", {31'd0, irq}, {31'd0, (refSrc & ~refMask & 3) != 0});
      check(tagOf(rdAddr), "read vs model", rdData, DATA_W'(expRead(rdAddr)));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 50000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic drive(input logic [NUM_EVT-1:0] e, input logic we,
                       input logic [ADDR_W-1:0] wa, input logic [NUM_EVT-1:0] wd);
    @(posedge clk);
    #2;
    evtPulse = e;
    wrEn = we;
    wrAddr = wa;
    wrData = wd;
  endtask

  task automatic idle();
    drive('0, 1'b0, '0, '0);
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  initial begin
    logic [DATA_W-1:0] v;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1;
    // R1 reset state
    readReg(1, v); check("R1", "mask after reset", v, 32'h3);
    readReg(0, v); check("R1", "source after reset", v, 32'h0);
    readReg(2, v); check("R1", "pending after reset", v, 32'h0);
    check("R1", "irq after reset", {31'd0, irq}, 32'h0);

    // R2 sticky recording, lane 0 queued, lane 1 completed
    drive(2'b01, 0, 0, 0); idle();
    readReg(0, v); check("R2", "queued recorded", v, 32'h1);
    drive(2'b01, 0, 0, 0); idle();
    readReg(0, v); check("R2", "repeat keeps 1", v, 32'h1);
    drive(2'b10, 0, 0, 0); idle();
    readReg(0, v); check("R2", "completed recorded", v, 32'h3);

    // R3 full mask blocks pending
    readReg(2, v); check("R3", "masked pending", v, 32'h0);
    check("R3", "masked irq", {31'd0, irq}, 32'h0);

    // R4 unmask lane 0 after recording
    drive(0, 1, 1, 2'b10); idle();
    readReg(2, v); check("R4", "pending after unmask", v, 32'h1);
    check("R4", "irq after unmask", {31'd0, irq}, 32'h1);
    readReg(1, v); check("R9", "mask readback", v, 32'h2);

    // R6 multi-bit clear and zero write
    drive(0, 1, 0, 2'b11); idle();
    readReg(0, v); check("R6", "clear both", v, 32'h0);
    check("R5", "irq after clear", {31'd0, irq}, 32'h0);
    drive(2'b11, 0, 0, 0); idle();
    drive(0, 1, 0, 2'b00); idle();
    readReg(0, v); check("R6", "zero write no effect", v, 32'h3);

    // R7 pending clears, including a masked lane
    drive(0, 1, 2, 2'b10); idle();
    readReg(0, v); check("R7", "clear masked lane via pending", v, 32'h1);
    drive(0, 1, 2, 2'b00); idle();
    readReg(0, v); check("R7", "zero write no effect", v, 32'h1);
    drive(0, 1, 2, 2'b01); idle();
    readReg(0, v); check("R7", "clear lane 0 via pending", v, 32'h0);

    // R8 set wins against a clear
    drive(2'b01, 1, 0, 2'b01); idle();
    readReg(0, v); check("R8", "set beats source clear", v, 32'h1);
    drive(2'b10, 1, 2, 2'b11); idle();
    readReg(0, v); check("R8", "set beats pending clear", v, 32'h2);

    // R9 unused offsets
    drive(0, 1, 5, 2'b11); idle();
    readReg(1, v); check("R9", "mask untouched by unused write", v, 32'h2);
    readReg(0, v); check("R9", "source untouched by unused write", v, 32'h2);
    readReg(7, v); check("R9", "unused read zero", v, 32'h0);

    // R4 unmask lane 1 recorded while masked
    check("R4", "irq low while masked", {31'd0, irq}, 32'h0);
    drive(0, 1, 1, 2'b00); idle();
    readReg(2, v); check("R4", "lane 1 pending after unmask", v, 32'h2);
    check("R5", "irq with pending", {31'd0, irq}, 32'h1);

    // Random phase, compared every cycle by the model block
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      @(posedge clk);
      #2;
      rstN = (r[31:26] != 6'd0);
      evtPulse = (r[3:2] == 2'b00) ? r[1:0] : 2'b00;
      wrEn = r[4];
      wrAddr = r[7] ? ADDR_W'(r[11:8]) : ADDR_W'(r[6:5]);
      wrData = r[13:12];
      rdAddr = r[16] ? ADDR_W'(r[20:17]) : ADDR_W'(r[15:14]);
    end
    @(posedge clk);
    #2 rstN = 1'b1;
    idle();
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule